// File: doc/BRIEF.md
# Sync Timing Meter

The block measures the timing of a video hsync/vsync pair so that a host can identify the incoming format or notice that it has changed. Both sync inputs are asynchronous to the measurement clock. Each one passes through a synchronizer chain and then an edge detector. A single enable strobe arms the unit. The measurement then runs over exactly one frame or field. It opens at the next vsync rising edge and closes at the vsync rising edge that follows.

Horizontal timing comes from one line of the frame, and the host picks that line by number. The line period and the hsync high time are counted in measurement-clock cycles. Vertical timing is counted in hsync rising edges, not in clocks. After the closing edge, the unit publishes all results in the same cycle, raises its done flag, and stops. It holds those results until the host arms it again.

Top module: `sync_timing_meter`

## Requirements
- R1: After reset, busy, done, the miss flag, the saturation flag and every result output read zero.
- R2: A cycle with `meas_start` high makes busy 1 and done 0 from the next cycle on, and the unit then waits for a vsync rising edge to open the measurement.
- R3: Lines are numbered from 0. Line 0 begins at the first hsync rising edge after the opening vsync edge. `h_period` reports the number of clock cycles from the rising hsync edge of line `sel_line` to the next rising hsync edge.
- R4: `h_pulse` reports the number of clock cycles for which hsync stays high, starting at the rising edge of line `sel_line`.
- R5: `v_period` reports the number of hsync rising edges seen after the opening vsync edge and before the closing vsync edge.
- R6: `v_pulse` reports the number of hsync rising edges seen after the opening vsync edge while vsync is still high.
- R7: At the closing vsync edge, all results and flags update in one cycle, done goes to 1 and busy goes to 0.
- R8: Once a measurement has completed, further sync activity without a new `meas_start` leaves every result unchanged, and done stays at 1.
- R9: Suppose the period of line `sel_line` has not completed before the closing vsync edge, either because the line is never reached or because it is the last line. Then `h_period` and `h_pulse` read 0 and `line_miss` reads 1. Otherwise `line_miss` reads 0.
- R10: Every counter stops at its all-ones value instead of wrapping: 4095 for the 12-bit horizontal counts and 1023 for the 10-bit vertical counts. If any counter tried to go past that value during the measurement, `cnt_sat` reads 1 after completion. Otherwise it reads 0.
- R11: Each sync input passes through two synchronizer flops. If the closing vsync level is applied before clock edge k, done reads 1 after edge k+2 and still reads 0 after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running measurement clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous, active high |
| vsync_in | input | 1 | Vertical sync, asynchronous, active high |
| meas_start | input | 1 | One-cycle strobe that arms a new measurement |
| sel_line | input | LINE_W (10) | Number of the line used for horizontal timing |
| h_period | output | HCNT_W (12) | Period of the selected line, in clocks |
| h_pulse | output | HCNT_W (12) | Hsync high time on the selected line, in clocks |
| v_period | output | VCNT_W (10) | Frame length, in hsync rising edges |
| v_pulse | output | VCNT_W (10) | Vsync high time, in hsync rising edges |
| busy | output | 1 | Measurement armed or running |
| done | output | 1 | Measurement complete; results valid |
| line_miss | output | 1 | Selected line's period was not completed |
| cnt_sat | output | 1 | A counter saturated during the measurement |

## Verification
A table of frames varies the selected line, the number of lines per frame, the line period, the hsync width and the vsync width. One frame selects line 0, which shows whether numbering starts at the first hsync edge. Other frames use a one-clock pulse and a pulse half the period wide, which show whether the high time is counted separately from the period. Two frames select the last line and a line past the end, which tell a selected line that has not yet completed apart from one that was never reached. Directed runs feed a frame without re-arming to show that results are held, and use overlong lines and frames to tell saturation from wrap-around. They also time the done flag against the closing vsync edge to the exact cycle.

// File: rtl/stm_pkg.sv
package stm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } stm_state_e;

  typedef enum logic [1:0] {
    HP_WAIT = 2'd0,
    HP_MEAS = 2'd1,
    HP_DONE = 2'd2
  } stm_hphase_e;

  // Next measurement state: a start strobe always re-arms; the armed state
  // opens on a vsync edge, the running state closes on the next one.
  function automatic stm_state_e fsm_next(stm_state_e cur, logic start, logic vs_edge);
    stm_state_e nxt;
    nxt = cur;
    if (start) begin
      nxt = ST_ARM;
    end else begin
      case (cur)
        ST_ARM:  if (vs_edge) nxt = ST_RUN;
        ST_RUN:  if (vs_edge) nxt = ST_IDLE;
        default: nxt = ST_IDLE;
      endcase
    end
    return nxt;
  endfunction

  // Horizontal results are published only when the selected line's period closed.
  function automatic logic hline_complete(stm_hphase_e ph);
    return ph == HP_DONE;
  endfunction

endpackage

// File: rtl/stm_sync_edge.sv
module stm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[TOP];
  end

  assign lvl  = chain_q[TOP];
  assign rise = chain_q[TOP] & ~last_q;
endmodule

// File: rtl/stm_sat_counter.sv
module stm_sat_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load_one,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] sat_step(logic [W-1:0] v);
    return (v == MAXV) ? v : v + ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (clr)      q <= '0;
    else if (load_one) q <= ONE;
    else if (inc)      q <= sat_step(q);
  end

  assign ovf = inc && !clr && !load_one && (q == MAXV);
endmodule

// File: rtl/sync_timing_meter.sv
module sync_timing_meter
  import stm_pkg::*;
#(
  parameter int HCNT_W      = 12,
  parameter int VCNT_W      = 10,
  parameter int LINE_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              meas_start,
  input  logic [LINE_W-1:0] sel_line,
  output logic [HCNT_W-1:0] h_period,
  output logic [HCNT_W-1:0] h_pulse,
  output logic [VCNT_W-1:0] v_period,
  output logic [VCNT_W-1:0] v_pulse,
  output logic              busy,
  output logic              done,
  output logic              line_miss,
  output logic              cnt_sat
);
  localparam int             NSYNC    = 2;
  localparam int             IDX_HS   = 0;
  localparam int             IDX_VS   = 1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [LINE_W-1:0] LINE_ONE = {{(LINE_W-1){1'b0}}, 1'b1};

  // ---------------- synchronizers and edge detectors ----------------
  logic [NSYNC-1:0] sync_raw, sync_lvl, sync_rise;
  assign sync_raw = {vsync_in, hsync_in};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    stm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sync_raw[g]),
      .lvl  (sync_lvl[g]),
      .rise (sync_rise[g])
    );
  end

  logic hs_lvl, hs_rise, vs_lvl, vs_rise;
  assign hs_lvl  = sync_lvl[IDX_HS];
  assign hs_rise = sync_rise[IDX_HS];
  assign vs_lvl  = sync_lvl[IDX_VS];
  assign vs_rise = sync_rise[IDX_VS];

  // ---------------- measurement state ----------------
  stm_state_e  state_q;
  stm_hphase_e hph_q;
  logic [LINE_W-1:0] line_idx_q;
  logic pulse_on_q, vpulse_on_q, sat_q;

  // Named events, also observed by the checker.
  logic open_evt, close_evt, line_evt, sel_hit, h_end, run_now;
  assign run_now   = (state_q == ST_RUN) && !meas_start;
  assign open_evt  = (state_q == ST_ARM) && vs_rise && !meas_start;
  assign close_evt = run_now && vs_rise;
  assign line_evt  = run_now && hs_rise && !vs_rise;
  assign sel_hit   = line_evt && (hph_q == HP_WAIT) && (line_idx_q == sel_line);
  assign h_end     = line_evt && (hph_q == HP_MEAS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= fsm_next(state_q, meas_start, vs_rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hph_q <= HP_WAIT;
    else if (open_evt) hph_q <= HP_WAIT;
    else if (sel_hit)  hph_q <= HP_MEAS;
    else if (h_end)    hph_q <= HP_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                line_idx_q <= '0;
    else if (open_evt)                         line_idx_q <= '0;
    else if (line_evt && line_idx_q != LINE_MAX) line_idx_q <= line_idx_q + LINE_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pulse_on_q <= 1'b0;
    else if (open_evt) pulse_on_q <= 1'b0;
    else if (sel_hit)  pulse_on_q <= 1'b1;
    else if (!hs_lvl)  pulse_on_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vpulse_on_q <= 1'b0;
    else if (open_evt) vpulse_on_q <= 1'b1;
    else if (!vs_lvl)  vpulse_on_q <= 1'b0;
  end

  // ---------------- counters ----------------
  logic [HCNT_W-1:0] hper_q, hpw_q;
  logic [VCNT_W-1:0] vper_q, vpw_q;
  logic hper_ovf, hpw_ovf, vper_ovf, vpw_ovf, any_ovf;
  logic hper_inc, hpw_inc, vpw_inc;

  assign hper_inc = run_now && (hph_q == HP_MEAS) && !h_end;
  assign hpw_inc  = run_now && (hph_q == HP_MEAS) && pulse_on_q && hs_lvl;
  assign vpw_inc  = line_evt && vpulse_on_q && vs_lvl;

  stm_sat_counter #(.W(HCNT_W)) u_hper (
    .clk(clk), .rst_n(rst_n), .clr(open_evt), .load_one(sel_hit),
    .inc(hper_inc), .q(hper_q), .ovf(hper_ovf)
  );
  stm_sat_counter #(.W(HCNT_W)) u_hpw (
    .clk(clk), .rst_n(rst_n), .clr(open_evt), .load_one(sel_hit),
    .inc(hpw_inc), .q(hpw_q), .ovf(hpw_ovf)
  );
  stm_sat_counter #(.W(VCNT_W)) u_vper (
    .clk(clk), .rst_n(rst_n), .clr(open_evt), .load_one(1'b0),
    .inc(line_evt), .q(vper_q), .ovf(vper_ovf)
  );
  stm_sat_counter #(.W(VCNT_W)) u_vpw (
    .clk(clk), .rst_n(rst_n), .clr(open_evt), .load_one(1'b0),
    .inc(vpw_inc), .q(vpw_q), .ovf(vpw_ovf)
  );

  assign any_ovf = hper_ovf | hpw_ovf | vper_ovf | vpw_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sat_q <= 1'b0;
    else if (open_evt) sat_q <= 1'b0;
    else if (any_ovf)  sat_q <= 1'b1;
  end

  // ---------------- result publication ----------------
  logic h_ok;
  assign h_ok = hline_complete(hph_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_period  <= '0;
      h_pulse   <= '0;
      v_period  <= '0;
      v_pulse   <= '0;
      line_miss <= 1'b0;
      cnt_sat   <= 1'b0;
    end else if (close_evt) begin
      h_period  <= h_ok ? hper_q : '0;
      h_pulse   <= h_ok ? hpw_q  : '0;
      v_period  <= vper_q;
      v_pulse   <= vpw_q;
      line_miss <= !h_ok;
      cnt_sat   <= sat_q | any_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          done <= 1'b0;
    else if (meas_start) done <= 1'b0;
    else if (close_evt)  done <= 1'b1;
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/stm_checker.sv
module stm_checker #(
  parameter int HCNT_W = 12,
  parameter int VCNT_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              meas_start,
  input logic              busy,
  input logic              done,
  input logic              line_miss,
  input logic              close_evt,
  input logic [HCNT_W-1:0] h_period,
  input logic [HCNT_W-1:0] h_pulse,
  input logic [VCNT_W-1:0] v_period,
  input logic [VCNT_W-1:0] v_pulse
);
  // R2: a start strobe arms the unit and withdraws done
  a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    meas_start |=> (busy && !done));

  // R7: the closing edge ends the run and raises done
  a_r7_close_finishes: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> (done && !busy));

  // R7: results move only right after the closing edge
  a_r7_results_move_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(h_period) || !$stable(v_period) || !$stable(v_pulse) || !$stable(h_pulse))
      |-> $past(close_evt));

  // R8: an idle unit keeps its results and done flag without a start
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !meas_start) |=> ($stable(h_period) && $stable(v_period) && $stable(done)));

  // R9: a missed line publishes zero horizontal results
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    line_miss |-> (h_period == '0 && h_pulse == '0));

  // R4: the high time lies within the line period
  a_r4_pulse_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    h_pulse <= h_period);

  // R6: the vsync width lies within the frame
  a_r6_vpulse_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    v_pulse <= v_period);

  // R7: busy and done never overlap
  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind sync_timing_meter stm_checker #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .meas_start(meas_start), .busy(busy), .done(done),
  .line_miss(line_miss), .close_evt(close_evt), .h_period(h_period),
  .h_pulse(h_pulse), .v_period(v_period), .v_pulse(v_pulse)
);

// File: tb/tb_sync_timing_meter.sv
`timescale 1ns/1ps
module tb_sync_timing_meter;
  localparam int HW = 12;
  localparam int VW = 10;
  localparam int LW = 10;
  localparam int NVEC = 6;
  // columns: selected line, lines per frame, line period, hsync width, vsync width (lines)
  localparam int VEC [NVEC][5] = '{
    '{0, 10, 40, 5, 3},
    '{3, 12, 57, 9, 2},
    '{7,  8, 33, 1, 4},
    '{5, 20, 64, 32, 1},
    '{9, 10, 30, 4, 2},
    '{12, 10, 30, 4, 2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 1'b0, vs = 1'b0, start = 1'b0;
  logic [LW-1:0] sel = '0;
  logic [HW-1:0] h_period, h_pulse;
  logic [VW-1:0] v_period, v_pulse;
  logic busy, done, line_miss, cnt_sat;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sync_timing_meter dut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs), .meas_start(start),
    .sel_line(sel), .h_period(h_period), .h_pulse(h_pulse), .v_period(v_period),
    .v_pulse(v_pulse), .busy(busy), .done(done), .line_miss(line_miss), .cnt_sat(cnt_sat)
  );

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Frame: vsync rises, then the given lines; closing vsync rise is the last drive.
  task automatic send_frame(bit arm, int lines, int hper, int hwid, int vwid);
    vs = 1'b0; hs = 1'b0;
    repeat (4) @(negedge clk);
    if (arm) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2 busy after start", busy, 1);
      chk("R2 done cleared by start", done, 0);
    end
    repeat (3) @(negedge clk);
    vs = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < lines; i++) begin
      if (i == vwid) vs = 1'b0;
      hs = 1'b1;
      repeat (hwid) @(negedge clk);
      hs = 1'b0;
      repeat (hper - hwid) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    vs = 1'b1;
  endtask

  task automatic check_all(string tag, int hp, int hw, int vp, int vw, int miss, int sat);
    chk({tag, " R3 h_period"}, h_period, hp);
    chk({tag, " R4 h_pulse"}, h_pulse, hw);
    chk({tag, " R5 v_period"}, v_period, vp);
    chk({tag, " R6 v_pulse"}, v_pulse, vw);
    chk({tag, " R9 line_miss"}, line_miss, miss);
    chk({tag, " R10 cnt_sat"}, cnt_sat, sat);
    chk({tag, " R7 done"}, done, 1);
    chk({tag, " R7 busy"}, busy, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 h_period", h_period, 0);
    chk("R1 v_period", v_period, 0);
    chk("R1 flags", {line_miss, cnt_sat}, 0);

    // Table-driven frames
    for (int k = 0; k < NVEC; k++) begin
      int miss;
      sel = LW'(VEC[k][0]);
      send_frame(1'b1, VEC[k][1], VEC[k][2], VEC[k][3], VEC[k][4]);
      repeat (5) @(negedge clk);
      miss = (VEC[k][0] >= VEC[k][1] - 1) ? 1 : 0;
      check_all($sformatf("vec%0d", k), miss ? 0 : VEC[k][2], miss ? 0 : VEC[k][3],
                VEC[k][1], VEC[k][4], miss, 0);
    end

    // R8: a frame without re-arming leaves the last results in place
    sel = 10'd2;
    send_frame(1'b0, 6, 25, 3, 1);
    repeat (5) @(negedge clk);
    check_all("R8 hold", 0, 0, 10, 2, 1, 0);

    // R11: done timing against the closing vsync edge, plus a fresh measurement
    sel = 10'd1;
    send_frame(1'b1, 5, 20, 6, 2);
    @(negedge clk);
    @(negedge clk);
    chk("R11 done low after k+1", done, 0);
    @(negedge clk);
    chk("R11 done high after k+2", done, 1);
    repeat (2) @(negedge clk);
    check_all("R11 frame", 20, 6, 5, 2, 0, 0);

    // R10: line period beyond the 12-bit range
    sel = 10'd0;
    send_frame(1'b1, 3, 5000, 10, 1);
    repeat (5) @(negedge clk);
    check_all("R10 hper sat", 4095, 10, 3, 1, 0, 1);

    // R10: hsync width beyond the 12-bit range
    send_frame(1'b1, 3, 4300, 4200, 1);
    repeat (5) @(negedge clk);
    check_all("R10 hpw sat", 4095, 4095, 3, 1, 0, 1);

    // R10: frame longer than the 10-bit range
    sel = 10'd1;
    send_frame(1'b1, 1030, 8, 2, 2);
    repeat (5) @(negedge clk);
    check_all("R10 vper sat", 8, 2, 1023, 2, 0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule